// File: doc/BRIEF.md
# Time-Target Event Generator

This block watches a free-running 64-bit time value supplied from outside and compares it with a programmable 64-bit target. When the time first reaches or passes the target, it raises a sticky timer interrupt flag. It then moves the target on, in one of two ways. In reload mode it copies a separate 64-bit reload register into the target. In add mode it adds a 32-bit step to the current target, so a fixed step gives evenly spaced events without help from software.

Each compare event also reaches a set of event pins. There are two by default, and each pin has its own mode, polarity and output enable. The modes are a fixed-width pulse, a toggle, a copy of the interrupt flag, and a reserved code. Software programs all settings through a simple word-write port. It clears the flag by writing a one to a dedicated address.

Top module: `ptp_target_event`

## Requirements
- R1: After reset the interrupt flag is 0, every pin and pin enable is 0, every mode is 00, reload mode is selected, and the target and reload registers hold all ones.
- R2: A compare event happens in every cycle in which `time_now` is greater than or equal to the target. The interrupt flag reads 1 from the next cycle onward. A time one below the target causes no event.
- R3: Writing a word with bit 0 set to address 5 clears the interrupt flag. If a compare event happens in the same cycle as that write, the flag stays set.
- R4: With control bit 0 at 0 (reload), an event loads the target from the 64-bit reload register. Address 3 holds the reload low word and address 4 holds the high word.
- R5: With control bit 0 at 1 (add), an event adds the 32-bit value at address 3 to the target. With the time advancing by one per cycle, events are spaced exactly that many cycles apart.
- R6: Mode 00 (pulse) drives the pin active for exactly PULSE_CYC cycles, starting the cycle after the event. With the default 20 ns clock, PULSE_CYC is 5 (100 ns).
- R7: Mode 01 (toggle) inverts the pin once per event, which gives a square wave when events are periodic.
- R8: Mode 10 (flag copy) drives the pin from the interrupt flag. The pin follows the flag both when it is set and when it is cleared.
- R9: Mode 11 (reserved) holds the pin at its inactive level, even when events occur.
- R10: When a pin's polarity bit is 1, its active and inactive levels are swapped.
- R11: When a pin's enable bit is 0, that pin and its enable output are both 0, whatever the mode and events.
- R12: The control word is at address 0. Bit 0 selects add mode. Bits 2:1 hold the mode of pin 0 and bits 4:3 the mode of pin 1. Bits 6:5 are the pin enables and bits 8:7 the polarity bits. The target low word is at address 1 and the high word at address 2. A write to either target word takes priority over an event update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Free-running time value |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| tmr_irq | output | 1 | Sticky timer interrupt flag |
| evt_out | output | 2 | Event pin levels |
| evt_oe | output | 2 | Event pin enables |

## Verification
A target that was not updated after an event shows up at once: in reload or add mode the flag, or a toggle pin, fires again on the very next cycle. A wrong add step shows as uneven spacing between toggle edges within one period. A pulse counter that is loaded wrongly changes the pin width within PULSE_CYC cycles. An interrupt flag that is wrongly cleared or held is visible on a flag-copy pin in the cycle after the write.

// File: rtl/ptp_evt_pkg.sv
package ptp_evt_pkg;

  localparam int unsigned DW = 32;
  localparam int unsigned TW = 2 * DW;
  localparam int unsigned AW = 3;

  typedef enum logic [1:0] {
    EM_PULSE  = 2'b00,
    EM_TOGGLE = 2'b01,
    EM_FLAG   = 2'b10,
    EM_RSVD   = 2'b11
  } evt_mode_e;

  localparam logic [AW-1:0] A_CTRL    = 3'd0;
  localparam logic [AW-1:0] A_TGT_LO  = 3'd1;
  localparam logic [AW-1:0] A_TGT_HI  = 3'd2;
  localparam logic [AW-1:0] A_RLD_LO  = 3'd3;
  localparam logic [AW-1:0] A_RLD_HI  = 3'd4;
  localparam logic [AW-1:0] A_IRQ_CLR = 3'd5;

  // Target after an add-mode event.
  function automatic logic [TW-1:0] tgt_advance(input logic [TW-1:0] tgt,
                                                input logic [DW-1:0] step);
    return tgt + {{(TW-DW){1'b0}}, step};
  endfunction

  // Pulse width in cycles, rounded up.
  function automatic int unsigned pulse_cycles(input int unsigned clk_ps,
                                               input int unsigned width_ns);
    return (width_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  // Pin level from the active level, polarity and enable.
  function automatic logic pin_level(input logic active, input logic pol,
                                     input logic oe);
    return oe & (active ^ pol);
  endfunction

endpackage

// File: rtl/ptp_evt_cfg.sv
module ptp_evt_cfg
  import ptp_evt_pkg::*;
#(
  parameter int unsigned NPINS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic                 add_sel,
  output logic [2*NPINS-1:0]   mode,
  output logic [NPINS-1:0]     oe,
  output logic [NPINS-1:0]     pol,
  output logic [TW-1:0]        rld,
  output logic                 tgt_wr_lo,
  output logic                 tgt_wr_hi,
  output logic                 irq_clr
);
  localparam int unsigned MODE_LSB = 1;
  localparam int unsigned OE_LSB   = MODE_LSB + 2 * NPINS;
  localparam int unsigned POL_LSB  = OE_LSB + NPINS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_sel <= 1'b0;
      mode    <= '0;
      oe      <= '0;
      pol     <= '0;
      rld     <= '1;
    end else if (wr_en) begin
      unique case (addr)
        A_CTRL: begin
          add_sel <= wdata[0];
          mode    <= wdata[MODE_LSB +: 2*NPINS];
          oe      <= wdata[OE_LSB +: NPINS];
          pol     <= wdata[POL_LSB +: NPINS];
        end
        A_RLD_LO: rld[DW-1:0]  <= wdata;
        A_RLD_HI: rld[TW-1:DW] <= wdata;
        default: ;
      endcase
    end
  end

  assign tgt_wr_lo = wr_en && (addr == A_TGT_LO);
  assign tgt_wr_hi = wr_en && (addr == A_TGT_HI);
  assign irq_clr   = wr_en && (addr == A_IRQ_CLR) && wdata[0];

endmodule

// File: rtl/ptp_evt_compare.sv
module ptp_evt_compare
  import ptp_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          add_sel,
  input  logic [TW-1:0] rld,
  input  logic          tgt_wr_lo,
  input  logic          tgt_wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          irq_clr,
  output logic [TW-1:0] target,
  output logic          hit,
  output logic          irq
);
  logic [TW-1:0] tgt_next;

  assign hit = (time_now >= target);

  always_comb begin
    tgt_next = target;
    if (tgt_wr_lo || tgt_wr_hi) begin
      if (tgt_wr_lo) tgt_next[DW-1:0]  = wdata;
      if (tgt_wr_hi) tgt_next[TW-1:DW] = wdata;
    end else if (hit) begin
      tgt_next = add_sel ? tgt_advance(target, rld[DW-1:0]) : rld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target <= '1;
      irq    <= 1'b0;
    end else begin
      target <= tgt_next;
      if (hit)          irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/ptp_evt_shaper.sv
module ptp_evt_shaper
  import ptp_evt_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       irq,
  input  logic [1:0] mode,
  input  logic       oe,
  input  logic       pol,
  output logic       pin,
  output logic       pin_oe
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt;
  logic          tog;
  logic          active;
  evt_mode_e     m;

  assign m = evt_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b0;
    end else begin
      if (hit && m == EM_PULSE) cnt <= CNT_LOAD;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
      if (hit && m == EM_TOGGLE) tog <= ~tog;
    end
  end

  always_comb begin
    unique case (m)
      EM_PULSE:  active = (cnt != '0);
      EM_TOGGLE: active = tog;
      EM_FLAG:   active = irq;
      default:   active = 1'b0;
    endcase
  end

  assign pin    = pin_level(active, pol, oe);
  assign pin_oe = oe;

endmodule

// File: rtl/ptp_target_event.sv
module ptp_target_event
  import ptp_evt_pkg::*;
#(
  parameter int unsigned NPINS    = 2,
  parameter int unsigned CLK_PS   = 20000,
  parameter int unsigned PULSE_NS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    time_now,
  input  logic             cfg_wr_en,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             tmr_irq,
  output logic [NPINS-1:0] evt_out,
  output logic [NPINS-1:0] evt_oe
);
  localparam int unsigned PULSE_CYC = pulse_cycles(CLK_PS, PULSE_NS);

  logic               cfg_add_sel;
  logic [2*NPINS-1:0] cfg_mode;
  logic [NPINS-1:0]   cfg_oe;
  logic [NPINS-1:0]   cfg_pol;
  logic [TW-1:0]      cfg_rld;
  logic               tgt_wr_lo;
  logic               tgt_wr_hi;
  logic               irq_clr;
  logic [TW-1:0]      target;
  logic               evt_hit;

  ptp_evt_cfg #(.NPINS(NPINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .add_sel   (cfg_add_sel),
    .mode      (cfg_mode),
    .oe        (cfg_oe),
    .pol       (cfg_pol),
    .rld       (cfg_rld),
    .tgt_wr_lo (tgt_wr_lo),
    .tgt_wr_hi (tgt_wr_hi),
    .irq_clr   (irq_clr)
  );

  ptp_evt_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_now  (time_now),
    .add_sel   (cfg_add_sel),
    .rld       (cfg_rld),
    .tgt_wr_lo (tgt_wr_lo),
    .tgt_wr_hi (tgt_wr_hi),
    .wdata     (cfg_wdata),
    .irq_clr   (irq_clr),
    .target    (target),
    .hit       (evt_hit),
    .irq       (tmr_irq)
  );

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    ptp_evt_shaper #(.PULSE_CYC(PULSE_CYC)) u_shp (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (evt_hit),
      .irq    (tmr_irq),
      .mode   (cfg_mode[2*gi +: 2]),
      .oe     (cfg_oe[gi]),
      .pol    (cfg_pol[gi]),
      .pin    (evt_out[gi]),
      .pin_oe (evt_oe[gi])
    );
  end

endmodule

// File: rtl/ptp_target_event_chk.sv
module ptp_target_event_chk #(
  parameter int unsigned NPINS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr_en,
  input logic               evt_hit,
  input logic [63:0]        target,
  input logic [63:0]        cfg_rld,
  input logic               cfg_add_sel,
  input logic [2*NPINS-1:0] cfg_mode,
  input logic [NPINS-1:0]   cfg_oe,
  input logic [NPINS-1:0]   cfg_pol,
  input logic               tmr_irq,
  input logic [NPINS-1:0]   evt_out,
  input logic [NPINS-1:0]   evt_oe
);
  p_hit_sets_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> tmr_irq);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && !cfg_add_sel && !cfg_wr_en) |=> target == $past(cfg_rld));

  p_add_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && cfg_add_sel && !cfg_wr_en)
      |=> target == $past(target) + {32'b0, $past(cfg_rld[31:0])});

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && cfg_mode[1:0] == 2'b00 && cfg_oe[0] && !cfg_wr_en)
      |=> evt_out[0] == !cfg_pol[0]);

  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && cfg_mode[1:0] == 2'b01 && cfg_oe[0] && !cfg_wr_en)
      |=> evt_out[0] != $past(evt_out[0]));

  p_flag_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[1:0] == 2'b10 && cfg_oe[0]) |-> evt_out[0] == (tmr_irq ^ cfg_pol[0]));

  p_reserved_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[1:0] == 2'b11 && cfg_oe[0]) |-> evt_out[0] == cfg_pol[0]);

  p_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_oe[0] |-> (!evt_out[0] && !evt_oe[0]));

endmodule

bind ptp_target_event ptp_target_event_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .evt_hit     (evt_hit),
  .target      (target),
  .cfg_rld     (cfg_rld),
  .cfg_add_sel (cfg_add_sel),
  .cfg_mode    (cfg_mode),
  .cfg_oe      (cfg_oe),
  .cfg_pol     (cfg_pol),
  .tmr_irq     (tmr_irq),
  .evt_out     (evt_out),
  .evt_oe      (evt_oe)
);

// File: tb/ptp_target_event_tb.sv
module ptp_target_event_tb;
  localparam int PULSE = 5;  // 100 ns at 20 ns

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tmr_irq;
  logic [1:0]  evt_out;
  logic [1:0]  evt_oe;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  ptp_target_event u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_now  (time_now),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tmr_irq   (tmr_irq),
    .evt_out   (evt_out),
    .evt_oe    (evt_oe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<100000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Writes high word first so the low word never becomes zero mid-update.
  task automatic set_target(input logic [63:0] v);
    wr(3'd2, v[63:32]);
    wr(3'd1, v[31:0]);
  endtask

  task automatic t_reset();
    check("R1 irq", tmr_irq, 0);
    check("R1 out", evt_out, 0);
    check("R1 oe", evt_oe, 0);
    time_now = 64'hFFFF_FFFF_FFFF_FFFE;
    repeat (3) @(negedge clk);
    check("R1 target all ones", tmr_irq, 0);
    time_now = 0;
  endtask

  task automatic t_pulse();
    // R12: pin0 pulse, pin1 pulse, both enabled, pin1 inverted
    wr(3'd0, 32'h160);
    wr(3'd3, 32'hFFFF_FFFF);
    set_target(64'd1000);
    wr(3'd5, 32'h1);
    check("R10 idle inverted", evt_out, 2'b10);
    check("R12 enables", evt_oe, 2'b11);
    time_now = 64'd999;
    @(negedge clk);
    check("R2 below target", tmr_irq, 0);
    time_now = 64'd1000;
    for (int k = 1; k <= PULSE + 2; k++) begin
      @(negedge clk);
      time_now = 0;
      if (k == 1) check("R2 irq set", tmr_irq, 1);
      check("R6 pulse width", evt_out, (k <= PULSE) ? 2'b01 : 2'b10);
    end
  endtask

  task automatic t_reload_flag();
    // pin0 flag copy, enabled, reload mode
    wr(3'd0, 32'h24);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'd500);
    set_target(64'd300);
    wr(3'd5, 32'h1);
    check("R8 cleared", evt_out[0], 0);
    time_now = 64'd300;
    @(negedge clk);
    time_now = 0;
    check("R8 flag high", evt_out[0], 1);
    wr(3'd5, 32'h1);
    check("R3 clear", tmr_irq, 0);
    check("R8 follows clear", evt_out[0], 0);
    time_now = 64'd499;
    @(negedge clk);
    check("R4 old target gone", tmr_irq, 0);
    time_now = 64'd500;
    @(negedge clk);
    time_now = 0;
    check("R4 reload target", tmr_irq, 1);
    wr(3'd5, 32'h1);
    // clear and event together
    cfg_wr_en = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'h1; time_now = 64'd500;
    @(negedge clk);
    cfg_wr_en = 1'b0; time_now = 0;
    check("R3 set wins", tmr_irq, 1);
  endtask

  task automatic t_add_toggle();
    int last = -1;
    int edges = 0;
    int bad_gap = 0;
    logic prev;
    // pin0 toggle, enabled, add mode, step 7
    wr(3'd0, 32'h23);
    wr(3'd3, 32'd7);
    set_target(64'd2000);
    time_now = 64'd1990;
    @(negedge clk);
    prev = evt_out[0];
    for (int i = 0; i < 80; i++) begin
      time_now = time_now + 1;
      @(negedge clk);
      if (evt_out[0] != prev) begin
        if (last >= 0 && i - last != 7) bad_gap++;
        last = i;
        edges++;
        prev = evt_out[0];
      end
    end
    time_now = 0;
    check("R5 even spacing", bad_gap, 0);
    check("R7 toggle edges", edges >= 10, 1);
  endtask

  task automatic t_rsvd_pol_oe();
    // pin0 reserved, enabled, inverted; pin1 pulse, disabled
    wr(3'd0, 32'hA6);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'd3000);
    set_target(64'd3000);
    check("R9 reserved idle", evt_out[0], 1);
    check("R11 disabled", evt_oe, 2'b01);
    time_now = 64'd3000;
    @(negedge clk);
    time_now = 0;
    check("R9 reserved after event", evt_out[0], 1);
    check("R11 pin stays released", evt_out[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_reload_flag();
    t_add_toggle();
    t_rsvd_pol_oe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule